// File: doc/BRIEF.md
# Super-I/O Configuration Port

This block is the configuration front end of a legacy-style I/O controller. It sits on a byte-wide I/O bus with an address, a write strobe, a read strobe and separate write and read data, and it answers at exactly two addresses. The lower of the two is the index port and the next one up is the data port. After reset the port is sealed. Software opens it by writing the open key to the index port on two consecutive index writes, and closes it again with a close key.

While the port is open, a write to the index port selects a register number, and reads and writes at the data port act on that register. Registers below 0x30 are global. One global register picks the logical device whose page is visible, and several read-only global registers identify the part. From 0x30 upward, accesses are passed to a downstream device-register bus. On that bus the address is the selected device number joined with the register number. Device 6 is the GPIO controller, which sits on that bus like any other page.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is sealed, the device select and the index are 0, `dev_addr_o` is 0x0000 and `io_rdata_o` is 0xFF.
- R2: The index port is at address BASE and the data port is at BASE+1. Accesses to any other address change no state and do not disturb a partly entered open key.
- R3: Two index writes of 0x87 with no other index write between them open the port. An index write of any other value between the two restarts the match. Data-port accesses between the two neither help nor break it.
- R4: While the port is open, an index write of 0xAA seals it. The device select and the index keep their values.
- R5: While the port is sealed, reads of either port return 0xFF. Index writes other than the keys and all data writes change nothing, and `dev_we_o` stays low.
- R6: While the port is open, an index write other than 0xAA stores the byte as the index, and an index-port read returns it.
- R7: Register 0x07 holds the logical device number. It can be written and read back, and it forms `dev_addr_o[15:8]`.
- R8: Registers 0x20 and 0x21 read the device ID, high byte then low byte. Register 0x22 reads the revision. Registers 0x23 and 0x24 read the manufacturer ID 0x1934, high byte first. Writes to these registers are ignored.
- R9: While the port is open and the index is 0x30 or above, a data write raises `dev_we_o` in the same cycle, with `dev_wdata_o` equal to the written byte and `dev_addr_o` equal to {device, index}. A data read returns `dev_rdata_i`.
- R10: Other global registers below 0x30 read 0x00 and ignore writes. They never raise `dev_we_o`.
- R11: `io_rdata_o` is registered. It takes the value read at the clock edge that samples a read strobe at either port address, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | ADDR_W | I/O bus address |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_rd_i | input | 1 | I/O read strobe, one cycle per read |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, registered |
| dev_addr_o | output | 16 | Device bus address {device, register} |
| dev_we_o | output | 1 | Device bus write enable |
| dev_wdata_o | output | 8 | Device bus write data |
| dev_rdata_i | input | 8 | Device bus read data, a combinational function of dev_addr_o |

## Verification
The bench builds the port with BASE set to the upper choice, 0x4E, and with a device ID and revision that differ from the defaults. Every identification byte therefore carries a distinct value, and an address decode left fixed at the default base fails at once. The downstream page is modelled as a function of both address bytes, so a wrong device select or a wrong index shows up on a forwarded read. A pseudo-random run mixes key bytes, index and data traffic and stray addresses. This covers open and seal sequences interleaved with forwarded writes.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_CLOSE  = 8'hAA;
  localparam logic [BYTE_W-1:0] REG_LDN    = 8'h07;
  localparam logic [BYTE_W-1:0] REG_ID_HI  = 8'h20;
  localparam logic [BYTE_W-1:0] REG_ID_LO  = 8'h21;
  localparam logic [BYTE_W-1:0] REG_REV    = 8'h22;
  localparam logic [BYTE_W-1:0] REG_MFG_HI = 8'h23;
  localparam logic [BYTE_W-1:0] REG_MFG_LO = 8'h24;
  localparam logic [BYTE_W-1:0] PAGE_START = 8'h30;
  localparam logic [BYTE_W-1:0] RD_IDLE    = 8'hFF;
  localparam logic [15:0]       MFG_ID     = 16'h1934;

  typedef enum logic [1:0] {
    ST_SEALED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } lock_st_e;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              open_o
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      unique case (st_q)
        ST_SEALED: st_d = (wdata_i == KEY_OPEN)  ? ST_HALF   : ST_SEALED;
        ST_HALF:   st_d = (wdata_i == KEY_OPEN)  ? ST_OPEN   : ST_SEALED;
        ST_OPEN:   st_d = (wdata_i == KEY_CLOSE) ? ST_SEALED : ST_OPEN;
        default:   st_d = ST_SEALED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_SEALED;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == ST_OPEN);

  // R3: opening happens only on an index write of the open key
  p_open_on_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(idx_wr_i && (wdata_i == KEY_OPEN)));

  // R4: the close key seals an open port
  p_close_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && (wdata_i == KEY_CLOSE)) |=> !open_o);
endmodule

// File: rtl/sio_glob_regs.sv
module sio_glob_regs
  import sio_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              idx_wr_i,
  input  logic              dat_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] idx_o,
  output logic [BYTE_W-1:0] ld_o
);
  logic idx_load, ld_load;

  assign idx_load = open_i && idx_wr_i && (wdata_i != KEY_CLOSE);
  assign ld_load  = open_i && dat_wr_i && (idx_o == REG_LDN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
      ld_o  <= '0;
    end else begin
      if (idx_load) idx_o <= wdata_i;
      if (ld_load)  ld_o  <= wdata_i;
    end
  end

  // R5: a sealed port keeps its index and device select
  p_sealed_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> ($stable(idx_o) && $stable(ld_o)));

  // R7: the device select moves only on a data write at register 0x07
  p_ld_only_reg7_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dat_wr_i && (idx_o == REG_LDN)) |=> $stable(ld_o));
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0]       DEV_ID  = 16'h5A21,
  parameter logic [BYTE_W-1:0] DEV_REV = 8'h03
) (
  input  logic              open_i,
  input  logic              sel_idx_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] ld_i,
  input  logic [BYTE_W-1:0] dev_rdata_i,
  output logic [BYTE_W-1:0] rd_val_o
);
  logic [BYTE_W-1:0] reg_val;

  always_comb begin
    if (idx_i >= PAGE_START) begin
      reg_val = dev_rdata_i;
    end else begin
      case (idx_i)
        REG_LDN:    reg_val = ld_i;
        REG_ID_HI:  reg_val = DEV_ID[15:8];
        REG_ID_LO:  reg_val = DEV_ID[7:0];
        REG_REV:    reg_val = DEV_REV;
        REG_MFG_HI: reg_val = MFG_ID[15:8];
        REG_MFG_LO: reg_val = MFG_ID[7:0];
        default:    reg_val = '0;
      endcase
    end
  end

  assign rd_val_o = !open_i   ? RD_IDLE :
                    sel_idx_i ? idx_i   : reg_val;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h002E,
  parameter logic [15:0] DEV_ID  = 16'h5A21,
  parameter logic [7:0]  DEV_REV = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic [15:0]       dev_addr_o,
  output logic              dev_we_o,
  output logic [7:0]        dev_wdata_o,
  input  logic [7:0]        dev_rdata_i
);
  localparam logic [ADDR_W-1:0] IDX_ADDR = BASE;
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE + ADDR_W'(1);

  logic hit_idx, hit_dat, port_open, rd_hit;
  logic [BYTE_W-1:0] idx_q, ld_q, rd_val;

  assign hit_idx = (io_addr_i == IDX_ADDR);
  assign hit_dat = (io_addr_i == DAT_ADDR);
  assign rd_hit  = io_rd_i && (hit_idx || hit_dat);

  sio_key_fsm u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (io_wr_i && hit_idx),
    .wdata_i  (io_wdata_i),
    .open_o   (port_open)
  );

  sio_glob_regs u_glob (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (port_open),
    .idx_wr_i (io_wr_i && hit_idx),
    .dat_wr_i (io_wr_i && hit_dat),
    .wdata_i  (io_wdata_i),
    .idx_o    (idx_q),
    .ld_o     (ld_q)
  );

  sio_rd_mux #(
    .DEV_ID  (DEV_ID),
    .DEV_REV (DEV_REV)
  ) u_rd (
    .open_i      (port_open),
    .sel_idx_i   (hit_idx),
    .idx_i       (idx_q),
    .ld_i        (ld_q),
    .dev_rdata_i (dev_rdata_i),
    .rd_val_o    (rd_val)
  );

  assign dev_addr_o  = {ld_q, idx_q};
  assign dev_wdata_o = io_wdata_i;
  assign dev_we_o    = port_open && io_wr_i && hit_dat && (idx_q >= PAGE_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     io_rdata_o <= RD_IDLE;
    else if (rd_hit) io_rdata_o <= rd_val;
  end

  // R5: a read of a sealed port answers 0xFF
  p_sealed_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !port_open) |=> (io_rdata_o == RD_IDLE));

  // R11: read data holds when no port read is sampled
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> $stable(io_rdata_o));
endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
  localparam logic [15:0] BASE    = 16'h004E;
  localparam logic [15:0] DEV_ID  = 16'hB7C1;
  localparam logic [7:0]  DEV_REV = 8'h2D;
  localparam logic [15:0] IDXP    = BASE;
  localparam logic [15:0] DATP    = BASE + 16'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [15:0] dev_addr;
  logic dev_we;
  logic [7:0] dev_wdata, dev_rdata;

  always #5 clk = ~clk;

  function automatic logic [7:0] page_mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign dev_rdata = page_mem(dev_addr);

  sio_cfg_port #(.ADDR_W(16), .BASE(BASE), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) i_sio_cfg_port (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .dev_addr_o(dev_addr), .dev_we_o(dev_we),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit m_open, m_half;
  logic [7:0] m_idx, m_ld, m_rdata;

  function automatic logic [7:0] m_reg(input logic [7:0] idx, input logic [7:0] ld);
    if (idx >= 8'h30) return page_mem({ld, idx});
    case (idx)
      8'h07: return ld;
      8'h20: return DEV_ID[15:8];
      8'h21: return DEV_ID[7:0];
      8'h22: return DEV_REV;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_half = 0; m_idx = 0; m_ld = 0; m_rdata = 8'hFF;
    end else begin
      if (io_rd && (io_addr == IDXP || io_addr == DATP))
        m_rdata = !m_open ? 8'hFF : (io_addr == IDXP) ? m_idx : m_reg(m_idx, m_ld);
      if (io_wr && io_addr == DATP && m_open && m_idx == 8'h07) m_ld = io_wdata;
      if (io_wr && io_addr == IDXP) begin
        if (!m_open) begin
          if (io_wdata == 8'h87) begin
            if (m_half) begin m_open = 1; m_half = 0; end
            else m_half = 1;
          end else m_half = 0;
        end else if (io_wdata == 8'hAA) m_open = 0;
        else m_idx = io_wdata;
      end
    end
  end

  // per-cycle comparison, sampled at the falling edge before inputs move
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_we;
      exp_we = m_open && io_wr && (io_addr == DATP) && (m_idx >= 8'h30);
      n_chk++;
      if (io_rdata !== m_rdata || dev_addr !== {m_ld, m_idx} || dev_we !== exp_we ||
          (exp_we && dev_wdata !== io_wdata)) begin
        n_fail++;
        $display("FAIL %s model: rdata=%h/%h addr=%h/%h we=%b/%b", cur_req,
                 io_rdata, m_rdata, dev_addr, {m_ld, m_idx}, dev_we, exp_we);
      end
    end
  end

  task automatic op(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk); #1;
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
  endtask

  task automatic idle();
    op(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    op(a, 1'b1, 1'b0, d); idle();
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    op(a, 1'b0, 1'b1, 8'h00); idle();
    chk(req, {8'h00, io_rdata}, {8'h00, exp});
  endtask

  task automatic unlock();
    wr(IDXP, 8'h87); wr(IDXP, 8'h87);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    cur_req = "R1";
    chk("R1", {8'h00, io_rdata}, 16'h00FF);
    chk("R1", dev_addr, 16'h0000);

    cur_req = "R5";
    rd_chk("R5", DATP, 8'hFF);
    rd_chk("R5", IDXP, 8'hFF);
    wr(DATP, 8'h44);
    wr(IDXP, 8'h07);
    chk("R5", dev_addr, 16'h0000);

    cur_req = "R3";
    wr(IDXP, 8'h87); wr(IDXP, 8'h11); wr(IDXP, 8'h87);
    rd_chk("R3", IDXP, 8'hFF);
    wr(IDXP, 8'hAA); wr(IDXP, 8'h00);
    wr(IDXP, 8'h87); wr(DATP, 8'h55); rd_chk("R3", DATP, 8'hFF); wr(IDXP, 8'h87);
    rd_chk("R3", IDXP, 8'h00);

    cur_req = "R2";
    wr(IDXP, 8'hAA);
    wr(IDXP, 8'h87); wr(16'h0080, 8'h11); wr(BASE + 16'd2, 8'h22); wr(IDXP, 8'h87);
    rd_chk("R2", IDXP, 8'h00);
    wr(IDXP, 8'h07); wr(BASE + 16'd2, 8'h33);
    rd_chk("R2", DATP, 8'h00);

    cur_req = "R6";
    wr(IDXP, 8'h22);
    rd_chk("R6", IDXP, 8'h22);

    cur_req = "R8";
    wr(IDXP, 8'h20); rd_chk("R8", DATP, DEV_ID[15:8]);
    wr(DATP, 8'h00); rd_chk("R8", DATP, DEV_ID[15:8]);
    wr(IDXP, 8'h21); rd_chk("R8", DATP, DEV_ID[7:0]);
    wr(IDXP, 8'h22); rd_chk("R8", DATP, DEV_REV);
    wr(IDXP, 8'h23); rd_chk("R8", DATP, 8'h19);
    wr(IDXP, 8'h24); wr(DATP, 8'hEE); rd_chk("R8", DATP, 8'h34);

    cur_req = "R7";
    wr(IDXP, 8'h07); wr(DATP, 8'h06);
    rd_chk("R7", DATP, 8'h06);
    chk("R7", dev_addr, 16'h0607);

    cur_req = "R9";
    wr(IDXP, 8'h35);
    op(DATP, 1'b1, 1'b0, 8'h9C);
    @(negedge clk);
    chk("R9", {15'd0, dev_we}, 16'd1);
    chk("R9", {8'h00, dev_wdata}, 16'h009C);
    chk("R9", dev_addr, 16'h0635);
    idle();
    rd_chk("R9", DATP, 8'h35 ^ 8'h06 ^ 8'h5A);

    cur_req = "R10";
    wr(IDXP, 8'h10);
    op(DATP, 1'b1, 1'b0, 8'h77);
    @(negedge clk);
    chk("R10", {15'd0, dev_we}, 16'd0);
    idle();
    rd_chk("R10", DATP, 8'h00);

    cur_req = "R11";
    repeat (4) idle();
    chk("R11", {8'h00, io_rdata}, 16'h0000);
    op(16'h0200, 1'b0, 1'b1, 8'h00); idle();
    chk("R11", {8'h00, io_rdata}, 16'h0000);

    cur_req = "R4";
    wr(IDXP, 8'hAA);
    rd_chk("R4", DATP, 8'hFF);
    chk("R4", dev_addr, 16'h0610);
    wr(DATP, 8'h01);
    chk("R4", {15'd0, dev_we}, 16'd0);

    cur_req = "R3";
    s = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      s = s * 32'd1103515245 + 32'd12345;
      case (s[18:16] % 8)
        3'd0: d = 8'h87;
        3'd1: d = 8'hAA;
        3'd2: d = 8'h07;
        3'd3: d = 8'h20 + {5'd0, s[26:24] % 3'd5};
        3'd4: d = 8'h30 + {4'd0, s[27:24]};
        3'd5: d = s[31:24];
        3'd6: d = 8'h87;
        default: d = 8'h10;
      endcase
      case (s[22:20])
        3'd0, 3'd1: op(IDXP, 1'b1, 1'b0, d);
        3'd2, 3'd3: op(DATP, 1'b1, 1'b0, s[31:24]);
        3'd4, 3'd5: op(DATP, 1'b0, 1'b1, 8'h00);
        3'd6: op(IDXP, 1'b0, 1'b1, 8'h00);
        default: op(16'h0081, 1'b1, 1'b0, 8'h87);
      endcase
    end
    idle(); idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule